// File: doc/BRIEF.md
# Up/down/center timer with repetition-gated update

This block is a free-running counter that counts in one of three shapes: up from zero with a wrap, down to zero with a reload, or up and then down in a triangle. Each wrap, and in the triangle shape each of the two turnarounds, is a repetition event. A repetition down-counter sets how many of these events pass between two update events. An update event is a one-cycle pulse on `uev_o`. On that pulse the preloaded auto-reload and repetition values are copied into their active registers.

Software sets the block up through a plain write port with three registers: a preloaded auto-reload value, a preloaded repetition value, and a control word. A strobe forces an update event at once. In the triangle shape, an odd repetition value puts every update on the top turnarounds only or on the bottom turnarounds only. Which of the two depends on the phase at which the repetition value was last loaded into the active counter. It does not depend on when software wrote it.

All pins are plain control and status. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ctr_rep_timer`

## Requirements
- R1: After reset, `cnt_o` is 0, `dir_o` is 0 (up) and `uev_o` is 0. The active repetition counter is 0, and both auto-reload registers hold `ARR_INIT`.
- R2: A write with `wr_en` high stores `wr_data` on the clock edge. Address 0 is the auto-reload preload. Address 1 is the repetition preload, which takes the low `RW` bits. Address 2 is control: bit 0 is run, bit 1 selects down counting in edge mode, and a nonzero bits [3:2] selects center mode. Address 3 is ignored. A stored value is acted on from the next cycle.
- R3: While run is 0, `cnt_o` holds its value, and `uev_o` stays 0 unless `ugen` is high.
- R4: In edge-up mode (control bits [3:1] = 000), `cnt_o` steps 0,1,…,A and then returns to 0, where A is the active auto-reload value. The cycle showing A is a repetition event. `dir_o` is 0.
- R5: In edge-down mode (bits [3:1] = 001), `cnt_o` steps down to 0 and then reloads A. The cycle showing 0 is a repetition event. `dir_o` is 1.
- R6: In center mode (A ≥ 1), `cnt_o` counts up to A and then down to 0, repeating. The cycle showing A while counting up is an event, and so is the cycle showing 0 while counting down. `dir_o` is 1 from the cycle after the top turnaround until the bottom turnaround.
- R7: On a repetition event, if the active repetition counter is 0, `uev_o` is high in that same cycle and the counter reloads from the preload. Otherwise the counter decrements. With preload N, updates therefore fall on every (N+1)-th event.
- R8: Writing the repetition preload has no immediate effect. From reset in center mode with preload 1, the first update falls on the first top turnaround and every later update also falls on a top turnaround. This holds whether the preload is written before or after run is set.
- R9: A cycle with `ugen` high drives `uev_o` high in that cycle and overrides counting. It reloads the repetition counter and the active auto-reload value. It sets `cnt_o` to 0 with direction up, or to the auto-reload preload in edge-down mode. After this, an odd preload in center mode puts the updates on bottom turnarounds.
- R10: A write to the auto-reload preload only takes effect at the next update. The wrap in progress still uses the old value, and later periods use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 auto-reload, 1 repetition, 2 control |
| wr_data | input | CW | Write data |
| ugen | input | 1 | Software update-generation strobe |
| cnt_o | output | CW | Counter value |
| dir_o | output | 1 | Counting direction, 1 = down |
| uev_o | output | 1 | Update-event pulse |

## Verification
The bench builds the block with its default parameters: CW = 16, RW = 8 and ARR_INIT = 4. It sweeps auto-reload values 1 to 4 and repetition values 0 to 3 in all three counting shapes, so every wrap, every turnaround and every update position falls within a few dozen cycles and is predicted from closed-form arithmetic. The small ARR_INIT lets a run started straight from reset reach its first update quickly, without a forced update. This brings within reach both orderings of the repetition write against the run bit, as well as the change of a period across an update.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    M_UP     = 2'd0,
    M_DOWN   = 2'd1,
    M_CENTER = 2'd2
  } tmr_mode_e;

  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned A_RELOAD = 0;
  localparam int unsigned A_REPEAT = 1;
  localparam int unsigned A_CTRL   = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned RW       = 8,
  parameter int unsigned ARR_INIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CW-1:0]       wr_data,
  output logic [CW-1:0]       arr_pre,
  output logic [RW-1:0]       rep_pre,
  output logic                run,
  output tmr_mode_e           mode
);
  localparam logic [CW-1:0] ARR_RST = CW'(ARR_INIT);

  logic       down_q;
  logic [1:0] ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_pre <= ARR_RST;
      rep_pre <= '0;
      run     <= 1'b0;
      down_q  <= 1'b0;
      ctr_q   <= 2'b00;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_RELOAD): arr_pre <= wr_data;
        ADDR_W'(A_REPEAT): rep_pre <= wr_data[RW-1:0];
        ADDR_W'(A_CTRL): begin
          run    <= wr_data[0];
          down_q <= wr_data[1];
          ctr_q  <= wr_data[3:2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (ctr_q != 2'b00) mode = M_CENTER;
    else if (down_q)    mode = M_DOWN;
    else                mode = M_UP;
  end

  AST_REP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_REPEAT)) |=> rep_pre == $past(wr_data[RW-1:0])); // R2
  AST_ARR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_RELOAD)) |=> arr_pre == $past(wr_data)); // R2
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  tmr_mode_e     mode,
  input  logic [CW-1:0] arr_act,
  input  logic [CW-1:0] arr_nxt,
  input  logic [CW-1:0] arr_pre,
  input  logic          ugen,
  output logic [CW-1:0] cnt,
  output logic          dir_o,
  output logic          evt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic dir_q;
  logic hit;

  always_comb begin
    case (mode)
      M_UP:     hit = (cnt >= arr_act);
      M_DOWN:   hit = (cnt == '0);
      M_CENTER: hit = dir_q ? (cnt == '0) : (cnt >= arr_act);
      default:  hit = 1'b0;
    endcase
  end

  assign evt   = run && !ugen && hit;
  assign dir_o = (mode == M_CENTER) ? dir_q : (mode == M_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= 1'b0;
    end else if (ugen) begin
      cnt   <= (mode == M_DOWN) ? arr_pre : '0;
      dir_q <= 1'b0;
    end else if (run) begin
      case (mode)
        M_UP: begin
          cnt   <= hit ? '0 : cnt + ONE;
          dir_q <= 1'b0;
        end
        M_DOWN: begin
          cnt   <= hit ? arr_nxt : cnt - ONE;
          dir_q <= 1'b0;
        end
        M_CENTER: begin
          if (hit) begin
            cnt   <= dir_q ? ONE : cnt - ONE;
            dir_q <= !dir_q;
          end else begin
            cnt   <= dir_q ? cnt - ONE : cnt + ONE;
          end
        end
        default: ;
      endcase
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ugen) |=> $stable(cnt)); // R3
  AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !evt); // R3
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UP && evt) |=> cnt == '0); // R4
  AST_TURN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CENTER && !evt && !ugen) |=> $stable(dir_q)); // R6
endmodule

// File: rtl/tmr_rep.sv
module tmr_rep #(
  parameter int unsigned CW       = 16,
  parameter int unsigned RW       = 8,
  parameter int unsigned ARR_INIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          ugen,
  input  logic [RW-1:0] rep_pre,
  input  logic [CW-1:0] arr_pre,
  output logic          uev,
  output logic [CW-1:0] arr_act,
  output logic [CW-1:0] arr_nxt
);
  localparam logic [CW-1:0] ARR_RST = CW'(ARR_INIT);

  logic [RW-1:0] rep_cnt;

  assign uev     = ugen || (evt && rep_cnt == '0);
  assign arr_nxt = uev ? arr_pre : arr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_cnt <= '0;
      arr_act <= ARR_RST;
    end else if (uev) begin
      rep_cnt <= rep_pre;
      arr_act <= arr_pre;
    end else if (evt) begin
      rep_cnt <= rep_cnt - 1'b1;
    end
  end

  AST_UEV_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> rep_cnt == $past(rep_pre)); // R7
  AST_REP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !uev) |=> rep_cnt == RW'($past(rep_cnt) - 1'b1)); // R7
  AST_REP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !ugen) |=> $stable(rep_cnt)); // R8
  AST_ARR_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> $stable(arr_act)); // R10
endmodule

// File: rtl/ctr_rep_timer.sv
module ctr_rep_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned RW       = 8,
  parameter int unsigned ARR_INIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          ugen,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic          uev_o
);
  logic [CW-1:0] arr_pre, arr_act, arr_nxt;
  logic [RW-1:0] rep_pre;
  logic          run, evt;
  tmr_mode_e     mode;

  tmr_regs #(.CW(CW), .RW(RW), .ARR_INIT(ARR_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .arr_pre(arr_pre), .rep_pre(rep_pre),
    .run(run), .mode(mode)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .arr_act(arr_act), .arr_nxt(arr_nxt), .arr_pre(arr_pre),
    .ugen(ugen), .cnt(cnt_o), .dir_o(dir_o), .evt(evt)
  );

  tmr_rep #(.CW(CW), .RW(RW), .ARR_INIT(ARR_INIT)) u_rep (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ugen(ugen),
    .rep_pre(rep_pre), .arr_pre(arr_pre), .uev(uev_o),
    .arr_act(arr_act), .arr_nxt(arr_nxt)
  );

  AST_UEV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ugen) |-> !uev_o); // R3
endmodule

// File: tb/tb_ctr_rep_timer.sv
module tb_ctr_rep_timer;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          ugen = 1'b0;
  logic [CW-1:0] cnt_o;
  logic          dir_o;
  logic          uev_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  ctr_rep_timer #(.CW(CW), .RW(8), .ARR_INIT(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ugen(ugen), .cnt_o(cnt_o), .dir_o(dir_o),
    .uev_o(uev_o)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 200000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int ctr_cnt(int k, int a);
    int j;
    if (k == 0) return 0;
    j = k % (2 * a);
    return (j <= a) ? j : 2 * a - j;
  endfunction

  function automatic int ctr_dir(int k, int a);
    int j;
    if (k == 0) return 0;
    j = k % (2 * a);
    return (j == 0 || j > a) ? 1 : 0;
  endfunction

  // center run from reset, repetition preload 1, auto-reload ARR_INIT = 4
  task automatic phase_loop(input int k0, input string tag);
    for (int k = k0; k <= 24; k++) begin
      int e;
      bit ev;
      ev = (k >= 4) && (k % 4 == 0);
      e  = k / 4 - 1;
      chk("R6", cnt_o, ctr_cnt(k, 4), {tag, " cnt"});
      chk("R8", uev_o, (ev && (e % 2 == 0)) ? 1 : 0, {tag, " update on overflow only"});
      @(negedge clk);
    end
  endtask

  initial begin
    do_reset();
    chk("R1", cnt_o, 0, "reset cnt");
    chk("R1", dir_o, 0, "reset dir");
    chk("R1", uev_o, 0, "reset uev");

    // R8: preload written before run
    wr(1, 1);
    wr(2, 5);
    phase_loop(0, "pre-run write");

    // R8: preload written after run, before the first update
    do_reset();
    wr(2, 5);
    chk("R3", uev_o, 0, "no update at start");
    wr(1, 1);
    phase_loop(1, "post-run write");

    // R2: address 3 ignored, then R10 shadowed reload change
    do_reset();
    wr(2, 0);
    wr(0, 2);
    wr(1, 0);
    wr(3, 16'hffff);
    chk("R2", cnt_o, 0, "addr3 ignored cnt");
    chk("R2", dir_o, 0, "addr3 ignored dir");
    ugen = 1'b1; #1;
    chk("R9", uev_o, 1, "ugen pulse");
    @(negedge clk); ugen = 1'b0;
    wr(2, 1);
    chk("R4", cnt_o, 0, "start");
    wr(0, 5);
    for (int k = 1; k <= 9; k++) begin
      int ec;
      ec = (k <= 2) ? k : (k - 3) % 6;
      chk("R10", cnt_o, ec, "reload shadow cnt");
      chk("R10", uev_o, (k == 2 || k == 8) ? 1 : 0, "reload shadow uev");
      @(negedge clk);
    end
    wr(2, 0);

    // sweep of shapes, reloads and repetition values
    for (int m = 0; m < 3; m++) begin
      for (int a = 1; a <= 4; a++) begin
        for (int r = 0; r <= 3; r++) begin
          int mb, kmax, c;
          string rq;
          mb = (m == 0) ? 0 : (m == 1) ? 2 : 4;
          rq = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
          wr(2, mb);
          wr(0, a);
          wr(1, r);
          ugen = 1'b1; #1;
          chk("R9", uev_o, 1, "ugen pulse");
          @(negedge clk); ugen = 1'b0;
          chk("R9", cnt_o, (m == 1) ? a : 0, "ugen start value");
          wr(2, mb | 1);
          kmax = 4 * (r + 1) * (a + 1);
          for (int k = 0; k < kmax; k++) begin
            int ecnt, edir, e;
            bit ev;
            if (m == 2) begin
              ecnt = ctr_cnt(k, a);
              edir = ctr_dir(k, a);
              ev   = (k >= a) && (k % a == 0);
              e    = k / a - 1;
            end else begin
              ecnt = (m == 0) ? k % (a + 1) : a - k % (a + 1);
              edir = m;
              ev   = (k % (a + 1)) == a;
              e    = k / (a + 1);
            end
            chk(rq, cnt_o, ecnt, "count");
            chk(rq, dir_o, edir, "direction");
            if (m == 2 && (r % 2 == 1))
              chk("R9", uev_o, (ev && (e % (r + 1) == r)) ? 1 : 0, "odd repeat after ugen on underflow");
            else
              chk("R7", uev_o, (ev && (e % (r + 1) == r)) ? 1 : 0, "update spacing");
            @(negedge clk);
          end
          wr(2, mb);
          c = int'(cnt_o);
          repeat (4) begin
            chk("R3", cnt_o, c, "hold cnt");
            chk("R3", uev_o, 0, "hold uev");
            @(negedge clk);
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule